// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block produces the timing pulses a UART serializer and deserializer need. From a fixed reference clock (nominally 24 MHz) it makes a 16x oversampling tick and a bit tick. The rate is set by a 16-bit integer divisor and a 3-bit fractional adjust. A full bit lasts `16 * divisor + fraction + 16` enabled reference cycles. The extra fractional cycles are spread over the first `fraction` sub-bit periods, so no single sub-period is longer than one cycle beyond the rest.

The block also turns a 7-bit line control word into frame parameters: the data width, the stop-bit count, the parity mode and an infrared-mode flag. The divisor, fraction and line control inputs mirror software registers. They are captured into internal holding registers only when `cfg_wr` pulses. That pulse also restarts the divider, so a rate change never yields a tick of mixed length. A clock enable gates the counting. A divisor of zero leaves the generator idle.

Top module: `ufrac_tick_gen`

## Requirements
- R1: After reset no tick is produced, and the decoded frame reports 5 data bits, one stop bit, parity code 0 (none) and infrared off.
- R2: While the held divisor is zero, `os_tick` and `bit_tick` stay low whatever `clk_en` does.
- R3: With held divisor D and fraction F, sub-period k (k = 0..15 after a restart) lasts D+1 enabled cycles, plus one more when k < F. The first `os_tick` is high in the cycle that follows the L0-th enabled rising edge after the `cfg_wr` edge, where L0 is the length of sub-period 0.
- R4: `bit_tick` is high together with the `os_tick` that closes sub-period 15, and at no other time, so bit ticks are 16*D+16+F enabled cycles apart.
- R5: A rising edge with `clk_en` low does not advance the divider, and no tick follows it.
- R6: A `cfg_wr` pulse restarts the divider. No tick is high in the following cycle, and the next tick comes one full sub-period 0 of the new settings later.
- R7: Changes on `divisor`, `fraction` or `line_ctrl` without `cfg_wr` affect neither the tick timing nor the decoded frame.
- R8: `data_bits` equals `line_ctrl[1:0] + 5` of the held word.
- R9: `two_stop` equals held `line_ctrl[2]`.
- R10: `parity` is 0 (none) when held `line_ctrl[5]` is 0. Otherwise `line_ctrl[4:3]` selects it: 00 gives 1 (odd), 01 gives 2 (even), 10 gives 3 (forced one) and 11 gives 4 (forced zero).
- R11: `infrared` equals held `line_ctrl[6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Count enable for the divider |
| cfg_wr | input | 1 | Capture the settings and restart the divider |
| divisor | input | 16 | Integer divisor value |
| fraction | input | 3 | Fractional adjust value |
| line_ctrl | input | 7 | Line control word |
| os_tick | output | 1 | 16x oversample tick, one cycle wide |
| bit_tick | output | 1 | Bit-boundary tick, one cycle wide |
| data_bits | output | 4 | Data bits per frame (5 to 8) |
| two_stop | output | 1 | Two stop bits when high |
| parity | output | 3 | Parity mode code |
| infrared | output | 1 | Infrared mode flag |

## Verification
The hardest case to reach is a `cfg_wr` that arrives in the middle of a sub-period. The divider is holding a partial count at that moment, and a faulty restart would emit one short or long tick. The stimulus runs a slow setting for a few cycles, so the counter is part-way through its second sub-period, and then applies a fast setting. It then times every sub-period of the new bit. A separate pass pulses `clk_en` in a pattern of two cycles on and one off. This checks that only enabled edges are counted and that no tick follows a disabled edge.

// File: rtl/ufrac_pkg.sv
package ufrac_pkg;

    localparam int LINE_W       = 7;
    localparam int LC_STOP_BIT  = 2;
    localparam int LC_PSEL_LO   = 3;
    localparam int LC_PSEL_HI   = 4;
    localparam int LC_PAR_ON    = 5;
    localparam int LC_IR_BIT    = 6;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_ONE   = 3'd3,
        PAR_ZERO  = 3'd4
    } parity_e;

    typedef struct packed {
        logic [3:0] data_bits;
        logic       two_stop;
        parity_e    parity;
        logic       infrared;
    } frame_t;

    function automatic parity_e pick_parity(input logic on, input logic [1:0] sel);
        parity_e p;
        if (!on) begin
            p = PAR_NONE;
        end else begin
            case (sel)
                2'b00:   p = PAR_ODD;
                2'b01:   p = PAR_EVEN;
                2'b10:   p = PAR_ONE;
                default: p = PAR_ZERO;
            endcase
        end
        return p;
    endfunction

    function automatic frame_t decode_line(input logic [LINE_W-1:0] lc);
        frame_t f;
        f.data_bits = 4'd5 + {2'b00, lc[1:0]};
        f.two_stop  = lc[LC_STOP_BIT];
        f.parity    = pick_parity(lc[LC_PAR_ON], lc[LC_PSEL_HI:LC_PSEL_LO]);
        f.infrared  = lc[LC_IR_BIT];
        return f;
    endfunction

endpackage

// File: rtl/ufrac_cfg_hold.sv
module ufrac_cfg_hold
    import ufrac_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [FRAC_W-1:0] fraction,
    input  logic [LINE_W-1:0] line_ctrl,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] frac_q,
    output frame_t            frame_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            frac_q  <= '0;
            frame_q <= decode_line('0);
        end else if (cfg_wr) begin
            div_q   <= divisor;
            frac_q  <= fraction;
            frame_q <= decode_line(line_ctrl);
        end
    end

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> ($stable(div_q) && $stable(frac_q) && $stable(frame_q)));

    // R8
    width_range_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_q.data_bits >= 4'd5) && (frame_q.data_bits <= 4'd8));

endmodule

// File: rtl/ufrac_divider.sv
module ufrac_divider #(
    parameter int DIV_W    = 16,
    parameter int FRAC_W   = 3,
    parameter int SUBTICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div,
    input  logic [FRAC_W-1:0] frac,
    output logic              os_tick,
    output logic              bit_tick
);

    localparam int SUB_W = $clog2(SUBTICKS);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBTICKS - 1);

    logic [CNT_W-1:0] cyc_q;
    logic [CNT_W-1:0] cyc_end;
    logic [SUB_W-1:0] sub_q;
    logic             stretch;
    logic             active;
    logic             wrap;

    // sub-periods with index below the fraction run one cycle longer
    assign stretch = (sub_q < SUB_W'(frac));
    assign cyc_end = {1'b0, div} + CNT_W'(stretch);
    assign active  = clk_en && (div != '0);
    assign wrap    = active && (cyc_q == cyc_end);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cyc_q    <= '0;
            sub_q    <= '0;
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            os_tick  <= wrap;
            bit_tick <= wrap && (sub_q == SUB_LAST);
            if (active) begin
                if (wrap) begin
                    cyc_q <= '0;
                    sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
        end
    end

    // R5
    gated_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> !os_tick);

    // R2
    idle_div_chk: assert property (@(posedge clk) disable iff (rst)
        (div == '0) |=> (!os_tick && !bit_tick));

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> !os_tick);

    // R4
    bit_in_os_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> os_tick);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_q <= ({1'b0, div} + CNT_W'(1)));

endmodule

// File: rtl/ufrac_tick_gen.sv
module ufrac_tick_gen
    import ufrac_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int FRAC_W   = 3,
    parameter int SUBTICKS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [FRAC_W-1:0] fraction,
    input  logic [LINE_W-1:0] line_ctrl,
    output logic              os_tick,
    output logic              bit_tick,
    output logic [3:0]        data_bits,
    output logic              two_stop,
    output logic [2:0]        parity,
    output logic              infrared
);

    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] frac_q;
    frame_t            frame_q;

    ufrac_cfg_hold #(
        .DIV_W  (DIV_W),
        .FRAC_W (FRAC_W)
    ) u_hold (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .divisor   (divisor),
        .fraction  (fraction),
        .line_ctrl (line_ctrl),
        .div_q     (div_q),
        .frac_q    (frac_q),
        .frame_q   (frame_q)
    );

    ufrac_divider #(
        .DIV_W    (DIV_W),
        .FRAC_W   (FRAC_W),
        .SUBTICKS (SUBTICKS)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .restart  (cfg_wr),
        .div      (div_q),
        .frac     (frac_q),
        .os_tick  (os_tick),
        .bit_tick (bit_tick)
    );

    assign data_bits = frame_q.data_bits;
    assign two_stop  = frame_q.two_stop;
    assign parity    = frame_q.parity;
    assign infrared  = frame_q.infrared;

endmodule

// File: tb/ufrac_tick_gen_bench.sv
module ufrac_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        clk_en;
    logic        cfg_wr;
    logic [15:0] divisor;
    logic [2:0]  fraction;
    logic [6:0]  line_ctrl;
    logic        os_tick;
    logic        bit_tick;
    logic [3:0]  data_bits;
    logic        two_stop;
    logic [2:0]  parity;
    logic        infrared;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    ufrac_tick_gen u_ufrac_tick_gen (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .cfg_wr    (cfg_wr),
        .divisor   (divisor),
        .fraction  (fraction),
        .line_ctrl (line_ctrl),
        .os_tick   (os_tick),
        .bit_tick  (bit_tick),
        .data_bits (data_bits),
        .two_stop  (two_stop),
        .parity    (parity),
        .infrared  (infrared)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sub_len(input int d, input int f, input int k);
        return d + 1 + ((k < f) ? 1 : 0);
    endfunction

    function automatic int exp_parity(input int lc);
        if (((lc >> 5) & 1) == 0) return 0;
        return ((lc >> 3) & 3) + 1;
    endfunction

    // called at a negedge; returns at the negedge after the capture edge
    task automatic apply_cfg(input int d, input int f, input int lc);
        divisor   = 16'(d);
        fraction  = 3'(f);
        line_ctrl = 7'(lc);
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // time one full bit with clk_en high throughout
    task automatic measure_bit(input int d, input int f, input string req);
        int total = 0;
        for (int s = 0; s < 16; s++) begin
            int n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!os_tick && n < 300);
            total += n;
            check(n == sub_len(d, f, s), req, n, sub_len(d, f, s));
            check(bit_tick == (s == 15), "R4", int'(bit_tick), (s == 15) ? 1 : 0);
        end
        check(total == 16 * d + 16 + f, "R4", total, 16 * d + 16 + f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        rst = 1'b1; clk_en = 1'b1; cfg_wr = 1'b0;
        divisor = '0; fraction = '0; line_ctrl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        seen = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (os_tick || bit_tick) seen = 1'b1;
        end
        check(!seen, "R1", int'(seen), 0);
        check(data_bits == 4'd5, "R1", int'(data_bits), 5);
        check(two_stop == 1'b0 && infrared == 1'b0, "R1", int'({two_stop, infrared}), 0);
        check(parity == 3'd0, "R1", int'(parity), 0);

        // R2: divisor zero stays idle, with the enable toggling
        apply_cfg(0, 5, 0);
        seen = 1'b0;
        for (int i = 0; i < 120; i++) begin
            clk_en = i[0];
            @(negedge clk);
            if (os_tick || bit_tick) seen = 1'b1;
        end
        clk_en = 1'b1;
        check(!seen, "R2", int'(seen), 0);

        // R3 / R4: sweep small divisors over every fraction
        foreach (divisor[i]) begin end
        for (int d = 1; d <= 5; d++) begin
            for (int f = 0; f < 8; f++) begin
                apply_cfg(d, f, 0);
                measure_bit(d, f, "R3");
            end
        end

        // R5: enable pattern two on, one off; count enabled edges only
        apply_cfg(2, 3, 0);
        begin
            int ecnt = 0;
            int s = 0;
            for (int i = 0; i < 400 && s < 16; i++) begin
                bit en_now;
                en_now = (i % 3) != 2;
                clk_en = en_now;
                @(negedge clk);
                if (en_now) ecnt++;
                if (os_tick) begin
                    check(en_now, "R5", int'(en_now), 1);
                    check(ecnt == sub_len(2, 3, s), "R5", ecnt, sub_len(2, 3, s));
                    ecnt = 0;
                    s++;
                end
            end
            check(s == 16, "R5", s, 16);
        end
        clk_en = 1'b1;

        // R6: restart in the middle of a sub-period
        apply_cfg(4, 0, 0);
        repeat (7) @(negedge clk);
        apply_cfg(1, 7, 0);
        check(!os_tick, "R6", int'(os_tick), 0);
        measure_bit(1, 7, "R6");

        // R7: raw inputs move without cfg_wr
        apply_cfg(3, 2, 7'h2B);
        divisor   = 16'd9;
        fraction  = 3'd0;
        line_ctrl = 7'h44;
        measure_bit(3, 2, "R7");
        check(data_bits == 4'd8, "R7", int'(data_bits), 8);
        check(parity == 3'd2, "R7", int'(parity), 2);
        check(infrared == 1'b0, "R7", int'(infrared), 0);

        // R8..R11: every line control word
        for (int lc = 0; lc < 128; lc++) begin
            apply_cfg(0, 0, lc);
            check(int'(data_bits) == (lc & 3) + 5, "R8", int'(data_bits), (lc & 3) + 5);
            check(int'(two_stop) == ((lc >> 2) & 1), "R9", int'(two_stop), (lc >> 2) & 1);
            check(int'(parity) == exp_parity(lc), "R10", int'(parity), exp_parity(lc));
            check(int'(infrared) == ((lc >> 6) & 1), "R11", int'(infrared), (lc >> 6) & 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule